// File: doc/BRIEF.md
# Interrupt polarity and latching front-end

This block sits between up to 64 interrupt sources and a parent interrupt controller that only understands active-high level requests. Every source line gets a mask bit, a reverse-polarity bit, a trigger-mode bit and a write-one end-of-interrupt control. Each raw input passes through a synchronizer. It is then corrected by its polarity bit. A level line presents the corrected value directly. An edge line sets a sticky latch on a rising edge of the corrected value. In both cases the parent sees a level that is high when active.

Software programs the block over a small synchronous register bus: one request cycle per access, with read data returned on the following cycle. The polarity registers read back exactly what was written. Software can therefore save them before power is removed and write them back afterwards with plain register accesses.

Top module: `irq_pol_frontend`

## Requirements
- R1: After reset every control bit is 0, so all lines are unmasked, use normal polarity and are in level mode. Reads of every group return 0, and irq_o is 0 while the inputs are low.
- R2: Register map: byte offset = group base + 4*k, where register k covers lines 16k..16k+15 in data bits [15:0] (line 16k+j in bit j). The group bases are mask 0x00, reverse polarity 0x10, end-of-interrupt 0x20 and trigger mode 0x30 (1 = edge). Write data bits [31:16] are ignored and read as 0. Read data appears on rdata_o in the cycle after the request. End-of-interrupt registers and unmapped offsets read 0.
- R3: The reverse-polarity registers read back the last value written. Clearing a bit takes that line back to normal polarity, and the bit does not stay stuck set.
- R4: In level mode irq_o[n] = (irq_i[n] XOR polarity[n]) AND NOT mask[n]. It follows an input change after two clock edges and a register write after one edge.
- R5: In edge mode a rising edge of the polarity-corrected input sets the line's latch, and irq_o rises three clock edges after the input change. The latch holds after the input returns.
- R6: Writing 1 to a line's end-of-interrupt bit clears its latch at that write edge. Writing 0 has no effect, and nothing is stored. A new edge in the same cycle wins over the clear.
- R7: A masked line drives irq_o low, but its edge latch keeps capturing. Unmasking shows a pending latch at once.
- R8: With the polarity bit set, an edge-mode line latches on a falling edge of the raw input and ignores a rising one.
- R9: A line switched from reversed back to normal polarity again treats a high input as active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_i | input | NUM_LINES | Raw interrupt inputs (asynchronous) |
| irq_o | output | NUM_LINES | Active-high level requests to the parent |

## Verification
Each result has a fixed delay, and the bench samples it on the falling edge at that point. A level-mode line shows an input change after two rising edges. An edge-mode latch shows it after three, with the two-edge point also checked as still low. Mask, polarity and end-of-interrupt writes show on irq_o right after the write edge, and read data is sampled one edge after the request. Polarity is always changed while end-of-interrupt writes are available to discard the spurious edge that the change itself creates.

// File: rtl/irqfe_pkg.sv
package irqfe_pkg;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 8;
  localparam int REG_BITS = 16;

  typedef enum logic [1:0] {
    GRP_MASK = 2'd0,
    GRP_POL  = 2'd1,
    GRP_EOI  = 2'd2,
    GRP_TRIG = 2'd3
  } grp_e;
endpackage

// File: rtl/irqfe_regs.sv
module irqfe_regs
  import irqfe_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] edge_o,
  output logic [NUM_LINES-1:0] eoi_o
);
  localparam int NUM_REGS = (NUM_LINES + REG_BITS - 1) / REG_BITS;
  localparam int PAD_W    = NUM_REGS * REG_BITS;

  logic [PAD_W-1:0] mask_q, pol_q, trig_q, eoi_d;
  logic [BUS_W-1:0] rdata_q, rdata_d;
  grp_e             grp;
  logic [1:0]       idx;
  logic             hit;

  assign grp = grp_e'(addr_i[5:4]);
  assign idx = addr_i[3:2];
  assign hit = req_i && (addr_i[7:6] == 2'b00) && (addr_i[1:0] == 2'b00)
               && (int'(idx) < NUM_REGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (hit && we_i) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (idx == 2'(r)) begin
          case (grp)
            GRP_MASK: mask_q[r*REG_BITS +: REG_BITS] <= wdata_i[REG_BITS-1:0];
            GRP_POL:  pol_q[r*REG_BITS +: REG_BITS]  <= wdata_i[REG_BITS-1:0];
            GRP_TRIG: trig_q[r*REG_BITS +: REG_BITS] <= wdata_i[REG_BITS-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  // end-of-interrupt is a pulse only; nothing is stored
  always_comb begin
    eoi_d = '0;
    if (hit && we_i && grp == GRP_EOI) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (idx == 2'(r)) eoi_d[r*REG_BITS +: REG_BITS] = wdata_i[REG_BITS-1:0];
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    if (hit && !we_i) begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (idx == 2'(r)) begin
          case (grp)
            GRP_MASK: rdata_d[REG_BITS-1:0] = mask_q[r*REG_BITS +: REG_BITS];
            GRP_POL:  rdata_d[REG_BITS-1:0] = pol_q[r*REG_BITS +: REG_BITS];
            GRP_TRIG: rdata_d[REG_BITS-1:0] = trig_q[r*REG_BITS +: REG_BITS];
            default:  rdata_d = '0;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q[NUM_LINES-1:0];
  assign pol_o   = pol_q[NUM_LINES-1:0];
  assign edge_o  = trig_q[NUM_LINES-1:0];
  assign eoi_o   = eoi_d[NUM_LINES-1:0];

  // R3: polarity register 0 holds what was written
  p_pol_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == 8'h10) |=> (pol_o[REG_BITS-1:0] == $past(wdata_i[REG_BITS-1:0])));

  // R6: no clear pulse without a bus write
  p_eoi_needs_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_i && we_i)) |-> (eoi_o == '0));
endmodule

// File: rtl/irqfe_line.sv
module irqfe_line #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic pol_i,
  input  logic mask_i,
  input  logic edge_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic corr, prev_q, rise, latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign corr = sync_q[SYNC_STAGES-1] ^ pol_i;
  assign rise = corr && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= corr;
      // new edge wins over a simultaneous clear
      if (edge_i && rise)  latch_q <= 1'b1;
      else if (eoi_i)      latch_q <= 1'b0;
    end
  end

  assign irq_o = (edge_i ? latch_q : corr) && !mask_i;

  // R5: a corrected rising edge in edge mode sets the latch, even when masked (R7)
  p_latch_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && rise) |=> latch_q);

  // R5: latch holds until a clear
  p_latch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_q && !eoi_i) |=> latch_q);

  // R6: a clear with no new edge empties the latch
  p_eoi_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !(edge_i && rise)) |=> !latch_q);

  // R7: output only high in edge mode when latch is set
  p_edge_out_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && irq_o) |-> latch_q);
endmodule

// File: rtl/irq_pol_frontend.sv
module irq_pol_frontend
  import irqfe_pkg::*;
#(
  parameter int NUM_LINES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BUS_W-1:0]     wdata_i,
  output logic [BUS_W-1:0]     rdata_o,
  input  logic [NUM_LINES-1:0] irq_i,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [NUM_LINES-1:0] mask, pol, trig, eoi;

  initial begin
    if (NUM_LINES < 1 || NUM_LINES > 64) $error("NUM_LINES out of range");
    if (SYNC_STAGES < 2) $error("SYNC_STAGES below 2");
  end

  irqfe_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .mask_o  (mask),
    .pol_o   (pol),
    .edge_o  (trig),
    .eoi_o   (eoi)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    irqfe_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (irq_i[n]),
      .pol_i  (pol[n]),
      .mask_i (mask[n]),
      .edge_i (trig[n]),
      .eoi_i  (eoi[n]),
      .irq_o  (irq_o[n])
    );
  end

  // R2: upper read bits are always zero
  p_rdata_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[BUS_W-1:16] == '0);

  // R7: masked lines stay low
  p_masked_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & mask) == '0);
endmodule

// File: tb/tb_irq_pol_frontend.sv
module tb_irq_pol_frontend;
  localparam int N = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [N-1:0] irq_i = '0;
  logic [N-1:0] irq_o;

  int errors = 0, checks = 0;
  bit done = 0;

  irq_pol_frontend dut (.*);

  always #10 clk_i = ~clk_i;

  // {mask, polarity, input, expected} for lines 0..15, level mode (R4)
  localparam logic [63:0] VEC [5] = '{
    {16'h0000, 16'h0000, 16'h00F0, 16'h00F0},
    {16'h0030, 16'h0000, 16'h00F0, 16'h00C0},
    {16'h0000, 16'h000F, 16'h00F0, 16'h00FF},
    {16'h8001, 16'hFF00, 16'h0F0F, 16'h700E},
    {16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    req_i = 0;
    d = rdata_o;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    tick(3);
    rst_ni = 1;
    tick(2);

    // R1: reset state
    chk("R1 irq_o", irq_o, '0);
    rd(8'h00, d); chk("R1 mask", d, 0);
    rd(8'h1C, d); chk("R1 pol", d, 0);
    rd(8'h30, d); chk("R1 trig", d, 0);

    // R2: map, upper bits ignored, eoi and unmapped read 0
    wr(8'h14, 32'hABCD1234);
    rd(8'h14, d); chk("R2 readback", d, 32'h0000_1234);
    rd(8'h24, d); chk("R2 eoi reads 0", d, 0);
    rd(8'h40, d); chk("R2 unmapped", d, 0);
    wr(8'h14, 32'h0);

    // R4: table of level-mode vectors
    foreach (VEC[i]) begin
      wr(8'h00, {16'h0, VEC[i][63:48]});
      wr(8'h10, {16'h0, VEC[i][47:32]});
      irq_i[15:0] = VEC[i][31:16];
      tick(2);
      chk($sformatf("R4 vec%0d", i), {48'h0, irq_o[15:0]}, {48'h0, VEC[i][15:0]});
    end
    wr(8'h00, 0); wr(8'h10, 0); irq_i = '0; tick(3);

    // R4: exact latency on line 63
    irq_i[63] = 1;
    tick(1); chk("R4 line63 one edge", irq_o[63], 0);
    tick(1); chk("R4 line63 two edges", irq_o[63], 1);
    irq_i[63] = 0; tick(3);

    // R3/R9: line 17 reversed then back to normal
    wr(8'h14, 32'h0000_0002);
    chk("R3 reversed low input active", irq_o[17], 1);
    wr(8'h14, 32'h0);
    chk("R3 cleared not stuck", irq_o[17], 0);
    rd(8'h14, d); chk("R3 readback cleared", d, 0);
    irq_i[17] = 1; tick(2);
    chk("R9 high active again", irq_o[17], 1);
    irq_i[17] = 0; tick(3);

    // R5: edge mode on line 33 (reg 2 bit 1)
    wr(8'h38, 32'h0000_0002);
    irq_i[33] = 1;
    tick(2); chk("R5 not yet latched", irq_o[33], 0);
    tick(1); chk("R5 latched", irq_o[33], 1);
    irq_i[33] = 0; tick(4);
    chk("R5 held", irq_o[33], 1);

    // R6: write 0 no effect, write 1 clears
    wr(8'h28, 32'h0);
    chk("R6 zero write", irq_o[33], 1);
    wr(8'h28, 32'h0000_0002);
    chk("R6 cleared", irq_o[33], 0);

    // R7: masked line still latches
    wr(8'h08, 32'h0000_0002);
    irq_i[33] = 1; tick(3); irq_i[33] = 0; tick(3);
    chk("R7 masked low", irq_o[33], 0);
    wr(8'h08, 32'h0);
    chk("R7 pending shown", irq_o[33], 1);
    wr(8'h28, 32'h0000_0002);
    chk("R7 cleared", irq_o[33], 0);

    // R8: falling edge with reversed polarity
    wr(8'h18, 32'h0000_0002);
    tick(2);
    wr(8'h28, 32'h0000_0002);
    chk("R8 after config clear", irq_o[33], 0);
    irq_i[33] = 1; tick(4);
    chk("R8 rising ignored", irq_o[33], 0);
    irq_i[33] = 0;
    tick(2); chk("R8 falling not yet", irq_o[33], 0);
    tick(1); chk("R8 falling latched", irq_o[33], 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule